// File: doc/BRIEF.md
# SDI Timing Word and Line Number Embedder

This block turns a 20-bit component video stream with separate timing inputs into SDI data streams whose timing is carried inside the data. The inputs are a horizontal blank, a vertical blank, a field identifier and an active-picture qualifier. Each horizontal blanking interval receives an end-of-active-video sequence at its start and a start-of-active-video sequence at its end. In the high-definition and 3G modes, two line-number words follow every end sequence. Picture samples are delayed so that the start sequence fits into the four samples that come before the first sample of the line.

The block has one clock, and every clock carries one sample. Input sample bits 9:0 hold luma and bits 19:10 hold chroma. In HD and 3G modes the block drives a luma stream and a chroma stream, and both carry the same timing words. In SD mode the input is already a multiplexed 10-bit word stream on bits 9:0. It leaves on the luma stream only, with each timing word sent once. Three flag outputs mark timing words, end sequences and start sequences. The source must keep horizontal blanking at least 10 samples long and keep the vertical blank and field inputs constant through each line.

Top module: `sdi_sync_embedder`

## Requirements
- R1: While reset is held, ds_y_o reads 0x040, ds_c_o reads 0x200, and trs_o, eav_o and sav_o are all 0.
- R2: In HD (mode 00) and 3G (mode 10), an active input sample appears 6 clock edges after it is presented: ds_y_o takes bits 9:0 and ds_c_o takes bits 19:10.
- R3: In HD and 3G, a sample that is neither active nor part of a timing or line-number word leaves as ds_y_o = 0x040 and ds_c_o = 0x200, whatever its data bits hold.
- R4: The first blanked sample after a non-blanked one starts an end sequence of 0x3FF, 0x000, 0x000, XYZ with H = 1, on both streams in HD and 3G.
- R5: The four samples just before the first non-blanked sample of a line carry a start sequence of 0x3FF, 0x000, 0x000, XYZ with H = 0.
- R6: XYZ = {1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0} (bit 9 down to bit 0). F is the field input and V is the vertical blank input at the XYZ sample position.
- R7: In HD and 3G, the two words after every end-sequence XYZ are {~L[6], L[6:0], 00} and then {1, 000, L[10:7], 00} on both streams.
- R8: The line number L of an end sequence is 1 when its V is 1, the previous end sequence's V was 0 and its F is 0. Otherwise L is the previous number plus one. The count starts from 0 after reset.
- R9: In SD (mode 01), the timing words appear on ds_y_o only. No line-number words are inserted, so the sample after an XYZ is ordinary data, and ds_c_o is 0.
- R10: trs_o is 1 on each of the four words of every start or end sequence and 0 on line-number and video words. eav_o is 1 only on an end XYZ and sav_o only on a start XYZ.
- R11: With mode 11, no timing or line-number words are inserted, all flags stay 0, and video and blanking levels pass as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | 00 HD, 01 SD, 10 3G, 11 insertion off |
| vid_data_i | input | 20 | Chroma in 19:10, luma in 9:0 |
| vid_act_i | input | 1 | Sample carries picture |
| vid_hblank_i | input | 1 | Horizontal blanking |
| vid_vblank_i | input | 1 | Vertical blanking |
| vid_field_i | input | 1 | 0 first field, 1 second field |
| ds_y_o | output | 10 | Luma or multiplexed stream |
| ds_c_o | output | 10 | Chroma stream |
| trs_o | output | 1 | Timing word present |
| eav_o | output | 1 | End-sequence XYZ present |
| sav_o | output | 1 | Start-sequence XYZ present |

## Verification
A wrong end-sequence word index shifts or truncates the 3FF/000/000/XYZ pattern. It also displaces or drops the line-number words, which shows on the sample after the next blanking edge. A corrupted look-ahead tap moves the start sequence away from the first picture sample in the same line. A wrong line count shows up only in the line-number words, so frames of 40 lines with two fields and a repeated frame start are needed. These expose a failed restart at frame start and a wrong restart at the second field within one field.

// File: rtl/sdi_emb_pkg.sv
package sdi_emb_pkg;

    localparam int CW = 10;
    localparam int LW = 11;
    localparam int TRS_LEN = 4;

    typedef enum logic [1:0] {
        MODE_HD  = 2'b00,
        MODE_SD  = 2'b01,
        MODE_3G  = 2'b10,
        MODE_OFF = 2'b11
    } sdi_mode_e;

    typedef struct packed {
        logic          hb;
        logic          act;
        logic          vb;
        logic          fld;
        logic [2*CW-1:0] pix;
    } smp_t;

    localparam smp_t IDLE_SMP = '{hb: 1'b1, act: 1'b0, vb: 1'b0, fld: 1'b0, pix: '0};

    localparam logic [CW-1:0] BLANK_Y = 10'h040;
    localparam logic [CW-1:0] BLANK_C = 10'h200;

    function automatic logic [CW-1:0] xyz_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

    // word index 0..3 of a timing sequence
    function automatic logic [CW-1:0] trs_word(input logic [1:0] w, input logic f,
                                               input logic v, input logic h);
        logic [CW-1:0] r;
        case (w)
            2'd0:    r = '1;
            2'd3:    r = xyz_word(f, v, h);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [CW-1:0] ln_lo(input logic [LW-1:0] l);
        return {~l[6], l[6:0], 2'b00};
    endfunction

    function automatic logic [CW-1:0] ln_hi(input logic [LW-1:0] l);
        return {1'b1, 3'b000, l[10:7], 2'b00};
    endfunction

endpackage

// File: rtl/sdi_emb_hist.sv
module sdi_emb_hist
    import sdi_emb_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  smp_t              in_i,
    output smp_t [DEPTH-1:0]  tap_o
);

    smp_t [DEPTH-1:0] tap_d, tap_q;

    always_comb begin
        tap_d[0] = in_i;
        for (int k = 1; k < DEPTH; k++) begin
            tap_d[k] = tap_q[k-1];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_tap
            always_ff @(posedge clk) begin
                if (rst) tap_q[g] <= IDLE_SMP;
                else     tap_q[g] <= tap_d[g];
            end
        end
    endgenerate

    assign tap_o = tap_q;

endmodule

// File: rtl/sdi_emb_lncnt.sv
module sdi_emb_lncnt
    import sdi_emb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    input  logic          vb_i,
    input  logic          fld_i,
    output logic [LW-1:0] line_o
);

    typedef struct packed {
        logic [LW-1:0] cnt;
        logic          vprev;
    } lc_t;

    lc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (vb_i && !st_q.vprev && !fld_i) st_d.cnt = LW'(1);
            else                               st_d.cnt = st_q.cnt + LW'(1);
            st_d.vprev = vb_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign line_o = st_q.cnt;

    // a step with frame-start conditions must land on line 1
    AST_LINE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (step_i && vb_i && !st_q.vprev && !fld_i) |=> (line_o == LW'(1))) // R8
        else $error("line restart");

endmodule

// File: rtl/sdi_sync_embedder.sv
module sdi_sync_embedder
    import sdi_emb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode_i,
    input  logic [19:0]   vid_data_i,
    input  logic          vid_act_i,
    input  logic          vid_hblank_i,
    input  logic          vid_vblank_i,
    input  logic          vid_field_i,
    output logic [9:0]    ds_y_o,
    output logic [9:0]    ds_c_o,
    output logic          trs_o,
    output logic          eav_o,
    output logic          sav_o
);

    localparam int LOOK  = TRS_LEN;       // look-ahead taps for the start sequence
    localparam int POS   = LOOK;          // tap that feeds the output
    localparam int DEPTH = LOOK + 2;      // one more tap to see the previous sample
    localparam int IW    = 3;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [CW-1:0] y;
        logic [CW-1:0] c;
        logic          trs;
        logic          eav;
        logic          sav;
    } st_t;

    smp_t             in_smp;
    smp_t [DEPTH-1:0] tap;
    smp_t             cur, prv;
    st_t              st_d, st_q;
    sdi_mode_e        mode;
    logic             sd, en, run, sav_hit, eav_go, ln_step;
    logic [IW-1:0]    sav_w, w, last;
    logic [LW-1:0]    line;

    assign mode   = sdi_mode_e'(mode_i);
    assign in_smp = '{hb: vid_hblank_i, act: vid_act_i, vb: vid_vblank_i,
                      fld: vid_field_i, pix: vid_data_i};

    sdi_emb_hist #(.DEPTH(DEPTH)) i_hist (
        .clk   (clk),
        .rst   (rst),
        .in_i  (in_smp),
        .tap_o (tap)
    );

    sdi_emb_lncnt i_lncnt (
        .clk    (clk),
        .rst    (rst),
        .step_i (ln_step),
        .vb_i   (cur.vb),
        .fld_i  (cur.fld),
        .line_o (line)
    );

    always_comb begin
        cur  = tap[POS];
        prv  = tap[POS+1];
        sd   = (mode == MODE_SD);
        en   = (mode != MODE_OFF);
        last = sd ? IW'(3) : IW'(5);

        st_d      = st_q;
        st_d.idx  = '0;
        st_d.trs  = 1'b0;
        st_d.eav  = 1'b0;
        st_d.sav  = 1'b0;
        st_d.y    = cur.act ? cur.pix[CW-1:0] : BLANK_Y;
        st_d.c    = sd ? '0 : (cur.act ? cur.pix[2*CW-1:CW] : BLANK_C);
        ln_step   = 1'b0;
        w         = '0;

        // start sequence: find the first non-blank tap ahead of the output tap
        sav_hit = 1'b0;
        sav_w   = '0;
        run     = cur.hb;
        for (int j = LOOK - 1; j >= 0; j--) begin
            if (run && !tap[j].hb) begin
                sav_hit = 1'b1;
                sav_w   = IW'(j);
            end
            run = run && tap[j].hb;
        end

        eav_go = en && ((st_q.idx != '0) || (cur.hb && !prv.hb));

        if (eav_go) begin
            w        = st_q.idx;
            st_d.idx = (w == last) ? '0 : w + IW'(1);
            if (w <= IW'(3)) begin
                st_d.y   = trs_word(w[1:0], cur.fld, cur.vb, 1'b1);
                st_d.c   = sd ? '0 : trs_word(w[1:0], cur.fld, cur.vb, 1'b1);
                st_d.trs = 1'b1;
            end else if (w == IW'(4)) begin
                st_d.y = ln_lo(line);
                st_d.c = ln_lo(line);
            end else begin
                st_d.y = ln_hi(line);
                st_d.c = ln_hi(line);
            end
            if (w == IW'(3)) begin
                st_d.eav = 1'b1;
                ln_step  = 1'b1;
            end
        end else if (en && sav_hit) begin
            st_d.y   = trs_word(sav_w[1:0], cur.fld, cur.vb, 1'b0);
            st_d.c   = sd ? '0 : trs_word(sav_w[1:0], cur.fld, cur.vb, 1'b0);
            st_d.trs = 1'b1;
            st_d.sav = (sav_w == IW'(3));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{idx: '0, y: BLANK_Y, c: BLANK_C, trs: 1'b0, eav: 1'b0, sav: 1'b0};
        else     st_q <= st_d;
    end

    assign ds_y_o = st_q.y;
    assign ds_c_o = st_q.c;
    assign trs_o  = st_q.trs;
    assign eav_o  = st_q.eav;
    assign sav_o  = st_q.sav;

    AST_EAV_XYZ_H: assert property (@(posedge clk) disable iff (rst)
        eav_o |-> (trs_o && ds_y_o[9] && ds_y_o[6])) // R10
        else $error("end flag without H=1 word");

    AST_SAV_XYZ_H: assert property (@(posedge clk) disable iff (rst)
        sav_o |-> (trs_o && ds_y_o[9] && !ds_y_o[6])) // R10
        else $error("start flag without H=0 word");

    AST_EAV_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        eav_o |-> ($past(ds_y_o, 3) == 10'h3FF)) // R4
        else $error("end XYZ without preamble");

    AST_LN_AFTER_EAV: assert property (@(posedge clk) disable iff (rst)
        (eav_o && mode_i != 2'b01) |=> !trs_o) // R7
        else $error("line word missing after end XYZ");

    AST_OFF_NO_TRS: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |=> !trs_o) // R11
        else $error("timing word with insertion off");

    AST_SD_C_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b01) |=> (ds_c_o == '0)) // R9
        else $error("chroma stream not idle in SD");

endmodule

// File: tb/test_sdi_sync_embedder.sv
module test_sdi_sync_embedder;

    localparam int NMAX  = 2048;
    localparam int LINES = 40;
    localparam int LAT   = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'b00;
    logic [19:0] vid_data_i = '0;
    logic        vid_act_i = 1'b0, vid_hblank_i = 1'b1, vid_vblank_i = 1'b0, vid_field_i = 1'b0;
    logic [9:0]  ds_y_o, ds_c_o;
    logic        trs_o, eav_o, sav_o;

    int tests = 0, fails = 0;
    logic done = 1'b0;

    logic        hb_a [NMAX];
    logic        act_a [NMAX];
    logic        vb_a [NMAX];
    logic        f_a [NMAX];
    logic [19:0] d_a [NMAX];
    logic [9:0]  cy [NMAX];
    logic [9:0]  cc [NMAX];
    logic [2:0]  cf [NMAX];
    int n;

    always #4 clk = ~clk;

    sdi_sync_embedder i_sdi_sync_embedder (
        .clk(clk), .rst(rst), .mode_i(mode_i), .vid_data_i(vid_data_i),
        .vid_act_i(vid_act_i), .vid_hblank_i(vid_hblank_i), .vid_vblank_i(vid_vblank_i),
        .vid_field_i(vid_field_i), .ds_y_o(ds_y_o), .ds_c_o(ds_c_o),
        .trs_o(trs_o), .eav_o(eav_o), .sav_o(sav_o)
    );

    task automatic check(input string tag, input logic ok, input logic [19:0] act, input logic [19:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] m_xyz(input logic f, input logic v, input logic h);
        logic [9:0] r;
        r = 10'h200 | (10'(f) << 8) | (10'(v) << 7) | (10'(h) << 6)
          | (10'(v ^ h) << 5) | (10'(f ^ h) << 4) | (10'(f ^ v) << 3) | (10'(f ^ v ^ h) << 2);
        return r;
    endfunction

    function automatic logic [9:0] m_seq(input int k, input logic f, input logic v, input logic h);
        if (k == 0) return 10'h3FF;
        if (k == 3) return m_xyz(f, v, h);
        return 10'h000;
    endfunction

    task automatic push(input logic hb, input logic act, input logic vb, input logic f, input logic [19:0] d);
        hb_a[n] = hb; act_a[n] = act; vb_a[n] = vb; f_a[n] = f; d_a[n] = d;
        n++;
    endtask

    task automatic build();
        n = 0;
        for (int ln = 0; ln < LINES; ln++) begin
            int a, b;
            logic vb, f;
            f  = (ln % 20) >= 10;
            vb = (ln % 10) < 2;
            a  = (ln == 5) ? 1  : 8 + int'($urandom % 25);   // directed: one-sample line
            b  = (ln == 5) ? 10 : 10 + int'($urandom % 8);   // directed: shortest blanking
            for (int k = 0; k < b; k++) push(1'b1, 1'b0, vb, f, 20'($urandom));
            for (int k = 0; k < a; k++) push(1'b0, !vb, vb, f, 20'($urandom));
        end
    endtask

    task automatic run_seg(input logic [1:0] md);
        mode_i = md;
        rst = 1'b1;
        vid_hblank_i = 1'b1; vid_act_i = 1'b0; vid_vblank_i = 1'b0; vid_field_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset data", ds_y_o == 10'h040 && ds_c_o == 10'h200,
              {ds_y_o, ds_c_o}, {10'h040, 10'h200});
        check("R1 reset flags", {trs_o, eav_o, sav_o} == 3'b000,
              20'({trs_o, eav_o, sav_o}), 20'h0);
        build();
        rst = 1'b0;
        for (int t = 0; t < n + LAT + 2; t++) begin
            if (t >= LAT && t - LAT < n) begin
                cy[t-LAT] = ds_y_o; cc[t-LAT] = ds_c_o; cf[t-LAT] = {trs_o, eav_o, sav_o};
            end
            if (t < n) begin
                vid_hblank_i = hb_a[t]; vid_act_i = act_a[t]; vid_vblank_i = vb_a[t];
                vid_field_i = f_a[t]; vid_data_i = d_a[t];
            end else begin
                vid_hblank_i = 1'b1; vid_act_i = 1'b0;
            end
            @(negedge clk);
        end
        compare(md);
    endtask

    task automatic compare(input logic [1:0] md);
        logic [10:0] cnt = '0;
        logic vprev = 1'b0;
        logic sd, en;
        sd = (md == 2'b01);
        en = (md != 2'b11);
        for (int i = 0; i < n; i++) begin
            logic [9:0] ey, ec;
            logic [2:0] ef;
            string tag;
            int ek, sj, last;
            last = sd ? 3 : 5;
            ek = -1; sj = -1;
            ef = 3'b000;
            ey = act_a[i] ? d_a[i][9:0] : 10'h040;
            ec = sd ? 10'h000 : (act_a[i] ? d_a[i][19:10] : 10'h200);
            tag = act_a[i] ? "R2" : "R3";
            if (en && hb_a[i]) begin
                for (int k = 0; k <= last; k++)
                    if (i - k - 1 >= 0 && hb_a[i-k] && !hb_a[i-k-1]) ek = k;
                if (ek < 0) begin
                    for (int j = 4; j >= 1; j--) begin
                        logic ok;
                        ok = (i + j < n) && !hb_a[i+j];
                        for (int q = 1; q < j; q++) if (i + q >= n || !hb_a[i+q]) ok = 1'b0;
                        if (ok) sj = j;
                    end
                end
            end
            if (ek >= 0) begin
                if (ek <= 3) begin
                    ey = m_seq(ek, f_a[i], vb_a[i], 1'b1);
                    ec = sd ? 10'h000 : ey;
                    ef = {1'b1, ek == 3, 1'b0};
                    tag = (ek == 3) ? "R4 R6" : "R4";
                    if (ek == 3) begin
                        if (vb_a[i] && !vprev && !f_a[i]) cnt = 11'd1;
                        else cnt = cnt + 11'd1;
                        vprev = vb_a[i];
                    end
                end else if (ek == 4) begin
                    ey = {~cnt[6], cnt[6:0], 2'b00}; ec = ey; tag = "R7 R8";
                end else begin
                    ey = 10'h200 | (10'(cnt[10:7]) << 2); ec = ey; tag = "R7 R8";
                end
            end else if (sj > 0) begin
                ey = m_seq(4 - sj, f_a[i], vb_a[i], 1'b0);
                ec = sd ? 10'h000 : ey;
                ef = {1'b1, 1'b0, sj == 1};
                tag = (sj == 1) ? "R5 R6" : "R5";
            end
            if (sd) tag = {tag, " R9"};
            if (!en) tag = {tag, " R11"};
            check(tag, cy[i] == ey && cc[i] == ec, {cy[i], cc[i]}, {ey, ec});
            check(sd ? "R10 R9" : (en ? "R10" : "R10 R11"), cf[i] == ef, 20'(cf[i]), 20'(ef));
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        run_seg(2'b00);
        run_seg(2'b01);
        run_seg(2'b10);
        run_seg(2'b11);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule